// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides, for each identifier received on a CAN bus, whether the frame is kept and into which of two receive FIFOs it goes. It holds a bank of filters. Each filter is switched on or off, set to one 32-bit or two 16-bit comparison slots, and set to mask or list mode. Each filter also names the FIFO it feeds and holds two 32-bit data words. When a frame arrives, the block reports one clock later whether the frame is accepted, the FIFO it goes to, and the number of the filter that matched. That number travels with the frame into the FIFO.

Filters are written through a small word-addressed write port. A global configuration-state input stops matching while software edits the filters: every frame seen in that state is rejected. Clearing the input returns the bank to working state. The receive path and the bus interface are outside this block.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every filter is inactive and holds zero, and all result outputs are low. A frame presented after reset is rejected.
- R2: A write with `cfg_we_i` high updates storage at the clock edge. Address 0 holds the active bits, address 1 the width bits (1 = one 32-bit slot, 0 = two 16-bit slots), address 2 the mode bits (1 = list, 0 = mask) and address 3 the FIFO bits (1 = FIFO 1). Bit n of each of these words belongs to filter n. Data word k (k = 0 or 1) of filter n sits at address 4 + 2n + k. A frame in the cycle after a write sees the new value.
- R3: `res_valid_o` is high for exactly one cycle, in the cycle after `frame_valid_i` is high, and is low otherwise.
- R4: A filter whose active bit is 0 never matches, whatever its other settings.
- R5: 32-bit mask mode. The frame image is {id[28:0], 1, rtr, 0} for an extended frame and {id[10:0], 18'b0, 0, rtr, 0} for a standard frame. Word 0 holds the identifier and word 1 the mask. A mask bit of 1 forces that image bit to equal the stored bit; a mask bit of 0 ignores it.
- R6: 32-bit list mode. The filter matches when the 32-bit image equals word 0 or word 1.
- R7: 16-bit mask mode. The image is {id[28:18], rtr, 1, id[17:15]} for an extended frame and {id[10:0], rtr, 0, 3'b0} for a standard frame. Each word holds an identifier in bits [15:0] and its mask in bits [31:16]. The filter matches when either pair matches.
- R8: 16-bit list mode. The filter matches when the 16-bit image equals any of the four 16-bit halves of its two words.
- R9: When several filters match, the lowest-numbered one wins. `res_index_o` carries its number and `res_fifo_o` its FIFO bit.
- R10: A frame that matches no filter gives `res_valid_o` = 1 and `res_accept_o` = 0, with `res_fifo_o` and `res_index_o` at 0.
- R11: A frame presented while `cfg_mode_i` is 1 is rejected. Matching resumes on the first frame after `cfg_mode_i` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | 1 = configuration state, all frames rejected |
| cfg_we_i | input | 1 | Write strobe for filter storage |
| cfg_addr_i | input | ADDR_W (5) | Write address |
| cfg_wdata_i | input | 32 | Write data |
| frame_valid_i | input | 1 | A received identifier is presented this cycle |
| frame_id_i | input | 29 | Identifier; a standard identifier uses bits [10:0] |
| frame_ide_i | input | 1 | 1 = extended identifier |
| frame_rtr_i | input | 1 | 1 = remote frame |
| res_valid_o | output | 1 | Result strobe, one cycle after the frame |
| res_accept_o | output | 1 | Frame accepted |
| res_fifo_o | output | 1 | Target FIFO (0 or 1) |
| res_index_o | output | IDX_W (4) | Number of the matching filter |

## Verification
The hardest case to reach is several filters of different widths and modes all matching the same identifier, so that only the priority rule decides which FIFO and index are reported. The bench sets up filters in every width/mode combination and a catch-all mask filter at the highest number. It then sends identifiers aimed at overlapping filters, and switches the lower winner off between frames so the next one in line must take over. A cycle-by-cycle model in the bench recomputes the image, every filter and the priority from its own copy of the written configuration. Frames are also sent in the same cycle as writes and while the bank is in configuration state.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int ID_W    = 29;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  // register addresses
  localparam int SEL_ACT   = 0;
  localparam int SEL_WIDE  = 1;
  localparam int SEL_LIST  = 2;
  localparam int SEL_FIFO  = 3;
  localparam int WORD_BASE = 4;

  typedef struct packed {
    logic              act;
    logic              wide;
    logic              id_list;
    logic              fifo;
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
  } filt_cfg_t;

  function automatic logic [WORD_W-1:0] frame_img32(logic [ID_W-1:0] id, logic ide, logic rtr);
    logic [WORD_W-1:0] r;
    if (ide) r = {id, 1'b1, rtr, 1'b0};
    else     r = {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] frame_img16(logic [ID_W-1:0] id, logic ide, logic rtr);
    logic [HALF_W-1:0] r;
    if (ide) r = {id[28:18], rtr, 1'b1, id[17:15]};
    else     r = {id[10:0], rtr, 1'b0, 3'd0};
    return r;
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int N_FILT = 14,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output filt_cfg_t         cfg_o [N_FILT]
);
  localparam int N_WORD = 2 * N_FILT;

  logic [N_FILT-1:0] act_q, wide_q, list_q, fifo_q;
  logic [WORD_W-1:0] word_q [N_WORD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      wide_q <= '0;
      list_q <= '0;
      fifo_q <= '0;
      for (int i = 0; i < N_WORD; i++) word_q[i] <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == ADDR_W'(SEL_ACT))  act_q  <= cfg_wdata_i[N_FILT-1:0];
      if (cfg_addr_i == ADDR_W'(SEL_WIDE)) wide_q <= cfg_wdata_i[N_FILT-1:0];
      if (cfg_addr_i == ADDR_W'(SEL_LIST)) list_q <= cfg_wdata_i[N_FILT-1:0];
      if (cfg_addr_i == ADDR_W'(SEL_FIFO)) fifo_q <= cfg_wdata_i[N_FILT-1:0];
      for (int i = 0; i < N_WORD; i++)
        if (cfg_addr_i == ADDR_W'(WORD_BASE + i)) word_q[i] <= cfg_wdata_i;
    end
  end

  for (genvar n = 0; n < N_FILT; n++) begin : g_out
    assign cfg_o[n] = '{act: act_q[n], wide: wide_q[n], id_list: list_q[n],
                        fifo: fifo_q[n], w0: word_q[2*n], w1: word_q[2*n+1]};
  end

  assert_act_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(SEL_ACT)) |=> act_q == $past(cfg_wdata_i[N_FILT-1:0]));

  assert_word_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(WORD_BASE)) |=> word_q[0] == $past(cfg_wdata_i));
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
(
  input  filt_cfg_t         cfg_i,
  input  logic [WORD_W-1:0] img32_i,
  input  logic [HALF_W-1:0] img16_i,
  output logic              hit_o
);
  logic hit_raw;
  logic [HALF_W-1:0] id_a, id_b, id_c, id_d;

  assign id_a = cfg_i.w0[HALF_W-1:0];
  assign id_b = cfg_i.w0[WORD_W-1:HALF_W];
  assign id_c = cfg_i.w1[HALF_W-1:0];
  assign id_d = cfg_i.w1[WORD_W-1:HALF_W];

  always_comb begin
    if (cfg_i.wide) begin
      if (cfg_i.id_list) hit_raw = (img32_i == cfg_i.w0) || (img32_i == cfg_i.w1);
      else               hit_raw = ((img32_i ^ cfg_i.w0) & cfg_i.w1) == '0;
    end else begin
      // mask mode: id in low half, mask in high half
      if (cfg_i.id_list) hit_raw = (img16_i == id_a) || (img16_i == id_b) ||
                                   (img16_i == id_c) || (img16_i == id_d);
      else               hit_raw = (((img16_i ^ id_a) & id_b) == '0) ||
                                   (((img16_i ^ id_c) & id_d) == '0);
    end
  end

  assign hit_o = hit_raw & cfg_i.act;
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int N     = 14,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int N_FILT = 14,
  parameter int ADDR_W = $clog2(WORD_BASE + 2 * N_FILT),
  parameter int IDX_W  = $clog2(N_FILT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_valid_i,
  input  logic [28:0]       frame_id_i,
  input  logic              frame_ide_i,
  input  logic              frame_rtr_i,
  output logic              res_valid_o,
  output logic              res_accept_o,
  output logic              res_fifo_o,
  output logic [IDX_W-1:0]  res_index_o
);
  filt_cfg_t         cfg [N_FILT];
  logic [WORD_W-1:0] img32;
  logic [HALF_W-1:0] img16;
  logic [N_FILT-1:0] hit_vec;
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic              take;

  can_filt_regs #(.N_FILT(N_FILT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_o      (cfg)
  );

  assign img32 = frame_img32(frame_id_i, frame_ide_i, frame_rtr_i);
  assign img16 = frame_img16(frame_id_i, frame_ide_i, frame_rtr_i);

  for (genvar n = 0; n < N_FILT; n++) begin : g_filt
    can_filt_match u_match (
      .cfg_i  (cfg[n]),
      .img32_i(img32),
      .img16_i(img16),
      .hit_o  (hit_vec[n])
    );
  end

  can_filt_prio #(.N(N_FILT), .IDX_W(IDX_W)) u_prio (
    .req_i  (hit_vec),
    .found_o(found),
    .idx_o  (win_idx)
  );

  assign take = frame_valid_i && !cfg_mode_i && found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_accept_o <= 1'b0;
      res_fifo_o   <= 1'b0;
      res_index_o  <= '0;
    end else begin
      res_valid_o  <= frame_valid_i;
      res_accept_o <= take;
      res_fifo_o   <= take ? cfg[win_idx].fifo : 1'b0;
      res_index_o  <= take ? win_idx : '0;
    end
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> res_valid_o);

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !res_valid_o);

  assert_cfg_reject_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && cfg_mode_i) |=> !res_accept_o);

  assert_accept_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_accept_o |-> res_valid_o);

  assert_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (hit_vec[win_idx] &&
               ((hit_vec & ((N_FILT'(1) << win_idx) - N_FILT'(1))) == '0)));

  assert_index_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_accept_o |-> (res_index_o < IDX_W'(N_FILT)));
endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 14;
  localparam int AW = 5;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic fv = 1'b0, ide = 1'b0, rtr = 1'b0;
  logic [28:0] fid = '0;
  logic r_valid, r_acc, r_fifo;
  logic [IW-1:0] r_idx;

  int n_chk = 0, n_err = 0;

  // behavioural model state
  bit m_act[NF], m_wide[NF], m_list[NF], m_fifo[NF];
  logic [31:0] m_w[2*NF];
  bit e_valid = 0, e_acc = 0, e_fifo = 0;
  int e_idx = 0;
  string e_tag = "R1";

  can_accept_filter i_can_accept_filter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .frame_valid_i(fv),
    .frame_id_i(fid), .frame_ide_i(ide), .frame_rtr_i(rtr),
    .res_valid_o(r_valid), .res_accept_o(r_acc), .res_fifo_o(r_fifo), .res_index_o(r_idx)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  function automatic longint unsigned mk32(logic [28:0] id, bit x, bit r);
    if (x) return (longint'(id) * 8) + 4 + (r ? 2 : 0);
    return (longint'(id % 2048) * (64'd1 << 21)) + (r ? 2 : 0);
  endfunction

  function automatic int unsigned mk16(logic [28:0] id, bit x, bit r);
    if (x) return ((int'(id) / (1 << 18)) * 32) + (r ? 16 : 0) + 8 + ((int'(id) / (1 << 15)) % 8);
    return (int'(id % 2048) * 32) + (r ? 16 : 0);
  endfunction

  function automatic bit filt_hit(int n, logic [28:0] id, bit x, bit r);
    longint unsigned a = mk32(id, x, r);
    int unsigned b = mk16(id, x, r);
    int unsigned h[4];
    if (!m_act[n]) return 0;
    h[0] = m_w[2*n] % 65536;   h[1] = m_w[2*n] / 65536;
    h[2] = m_w[2*n+1] % 65536; h[3] = m_w[2*n+1] / 65536;
    if (m_wide[n]) begin
      if (m_list[n]) return (a == m_w[2*n]) || (a == m_w[2*n+1]);
      return ((a ^ m_w[2*n]) & m_w[2*n+1]) == 0;
    end
    if (m_list[n]) return (b == h[0]) || (b == h[1]) || (b == h[2]) || (b == h[3]);
    return (((b ^ h[0]) & h[1]) == 0) || (((b ^ h[2]) & h[3]) == 0);
  endfunction

  // one clock: check last cycle's result, drive new inputs, predict, update model
  task automatic step(bit we, int addr, logic [31:0] d, bit v, logic [28:0] id, bit x, bit r, string tag);
    bit hit_found = 0;
    @(negedge clk);
    n_chk++;
    if (r_valid !== e_valid || r_acc !== e_acc || r_fifo !== e_fifo || int'(r_idx) != e_idx) begin
      n_err++;
      $display("FAIL %s: valid/accept/fifo/index got %b %b %b %0d expected %b %b %b %0d",
               e_tag, r_valid, r_acc, r_fifo, r_idx, e_valid, e_acc, e_fifo, e_idx);
    end
    cfg_we = we; cfg_addr = AW'(addr); cfg_wdata = d;
    fv = v; fid = id; ide = x; rtr = r;
    e_valid = v; e_acc = 0; e_fifo = 0; e_idx = 0;
    if (v && !cfg_mode) begin
      for (int n = 0; n < NF; n++) begin
        if (!hit_found && filt_hit(n, id, x, r)) begin
          hit_found = 1; e_acc = 1; e_fifo = m_fifo[n]; e_idx = n;
        end
      end
    end
    e_tag = tag;
    if (we) begin
      for (int n = 0; n < NF; n++) begin
        if (addr == 0) m_act[n]  = d[n];
        if (addr == 1) m_wide[n] = d[n];
        if (addr == 2) m_list[n] = d[n];
        if (addr == 3) m_fifo[n] = d[n];
      end
      if (addr >= 4) m_w[addr-4] = d;
    end
  endtask

  task automatic wr(int addr, logic [31:0] d, string tag);
    step(1, addr, d, 0, '0, 0, 0, tag);
  endtask

  task automatic fr(logic [28:0] id, bit x, bit r, string tag);
    step(0, 0, '0, 1, id, x, r, tag);
  endtask

  initial begin
    for (int i = 0; i < 2*NF; i++) m_w[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, frame rejected with empty bank
    step(0, 0, '0, 0, '0, 0, 0, "R1");
    fr(29'h123, 0, 0, "R1");
    fr(29'h1ABCDEF, 1, 0, "R1");
    step(0, 0, '0, 0, '0, 0, 0, "R3");
    // filter 0: 32-bit mask, id[4:0] ignored, bit0 ignored
    wr(4, 32'(mk32(29'h1ABCDEF, 1, 0)), "R2");
    wr(5, 32'hFFFF_FF06, "R2");
    // filter 3: 32-bit list, FIFO 1
    wr(10, 32'(mk32(29'h123, 0, 0)), "R2");
    wr(11, 32'(mk32(29'h7FF, 0, 1)), "R2");
    // filter 5: 16-bit mask, two pairs, FIFO 1
    wr(14, {16'hFFF8, 16'(mk16(29'h0A0, 0, 0))}, "R2");
    wr(15, {16'hF000, 16'(mk16(29'h300, 0, 0))}, "R2");
    // filter 7: 16-bit list, four ids
    wr(18, {16'(mk16(29'h022, 0, 1)), 16'(mk16(29'h011, 0, 0))}, "R2");
    wr(19, {16'(mk16({11'h044, 18'h28000}, 1, 0)), 16'(mk16(29'h033, 0, 0))}, "R2");
    // filter 9: would match std 0x555 but stays inactive
    wr(22, 32'(mk32(29'h555, 0, 0)), "R2");
    wr(23, 32'(mk32(29'h555, 0, 0)), "R2");
    // filters 10 and 12: both list std 0x666
    wr(24, 32'(mk32(29'h666, 0, 0)), "R2");
    wr(25, 32'(mk32(29'h666, 0, 0)), "R2");
    wr(28, 32'(mk32(29'h666, 0, 0)), "R2");
    wr(29, 32'(mk32(29'h666, 0, 0)), "R2");
    wr(1, 32'h3609, "R2");
    wr(2, 32'h1688, "R2");
    wr(3, 32'h1028, "R2");
    // frame in the same cycle as the activation write sees old state
    step(1, 0, 32'h14A9, 1, 29'h123, 0, 0, "R2");
    fr(29'h123, 0, 0, "R6");
    // R5
    fr(29'h1ABCDEF, 1, 0, "R5");
    fr(29'h1ABCDE0, 1, 0, "R5");
    fr(29'h1ABCCEF, 1, 0, "R5");
    fr(29'h1ABCDEF, 1, 1, "R5");
    fr(29'h1ABCDEF, 0, 0, "R5");
    // R6
    fr(29'h7FF, 0, 1, "R6");
    fr(29'h7FF, 0, 0, "R6");
    fr(29'h123 << 18, 1, 0, "R6");
    // R7
    fr(29'h0A0, 0, 0, "R7");
    fr(29'h0A0 << 18, 1, 0, "R7");
    fr(29'h350, 0, 1, "R7");
    fr(29'h310 << 18, 1, 0, "R7");
    fr(29'h0A1, 0, 0, "R7");
    // R8
    fr(29'h011, 0, 0, "R8");
    fr(29'h022, 0, 1, "R8");
    fr(29'h022, 0, 0, "R8");
    fr(29'h033, 0, 0, "R8");
    fr({11'h044, 18'h28000}, 1, 0, "R8");
    fr({11'h044, 18'h20000}, 1, 0, "R8");
    // R4 and R10
    fr(29'h555, 0, 0, "R4");
    fr(29'h0F0, 0, 0, "R10");
    step(0, 0, '0, 0, '0, 0, 0, "R3");
    // R9: overlapping filters 10 and 12
    fr(29'h666, 0, 0, "R9");
    wr(0, 32'h10A9, "R9");
    fr(29'h666, 0, 0, "R9");
    // catch-all at filter 13 (32-bit mask, mask 0)
    wr(30, 32'h0, "R9");
    wr(31, 32'h0, "R9");
    wr(0, 32'h30A9, "R9");
    fr(29'h0F0, 0, 0, "R9");
    fr(29'h1ABCDEF, 1, 0, "R9");
    fr(29'h666, 0, 0, "R9");
    // R4: switching 13 off again leaves an unmatched id rejected
    wr(0, 32'h10A9, "R4");
    fr(29'h0F0, 0, 0, "R4");
    // R11: configuration state rejects everything
    cfg_mode = 1'b1;
    fr(29'h123, 0, 0, "R11");
    fr(29'h666, 0, 0, "R11");
    wr(11, 32'(mk32(29'h124, 0, 0)), "R11");
    cfg_mode = 1'b0;
    fr(29'h124, 0, 0, "R11");
    fr(29'h7FF, 0, 1, "R11");
    step(0, 0, '0, 0, '0, 0, 0, "R3");
    step(0, 0, '0, 0, '0, 0, 0, "R3");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule